// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block decides when the chip drops into its low-power state and how it climbs back out. Software arms the sequence through a small control word. Entry happens in one of two ways. In the first, the state machine falls into power-down as soon as the arm bit is seen. In the second, it parks and waits until the processor reports that it has gone to sleep on a wait-for-interrupt. While the chip is down, the crystal, the fast internal oscillator, the PLL and the system clock are forced off. The slow internal oscillator is left under software control.

A GPIO or UART wake pulse ends power-down and clears the arm bit at the same edge. If the stabilisation option is on, the system clock stays gated for a settling window after the wake. The length of that window depends on the oscillator that drives the system clock: the long window applies to the crystal, the short one to the fast internal oscillator. A sticky wake flag, cleared by writing 1 to it, records the wake when the wake interrupt is enabled. The interrupt output follows that flag.

Control word bits (write with `cfg_wr`, read on `cfg_rdata`): bit 0 arm, bit 1 wait-for-CPU, bit 2 wake-delay enable, bit 3 wake interrupt enable, bit 4 wake flag (a write of 1 clears it), bit 5 crystal on, bit 6 fast oscillator on, bit 7 slow oscillator on, bit 8 PLL on. State code on `seq_state`: 0 run, 1 waiting for CPU, 2 powered down, 3 wake delay.

Top module: `pdn_sequencer`

## Requirements
- R1: After reset, `seq_state` is 0, `cfg_rdata` is 0x0C0, `sysclk_en`, `fast_osc_en` and `slow_osc_en` are 1, and `xtal_en`, `pll_en` and `wake_irq` are 0.
- R2: With bit 1 clear, the edge after bit 0 becomes 1 moves the state from run to powered down (code 2).
- R3: With bit 1 set, an armed run state moves to waiting (code 1). It stays there until `cpu_sleep` is 1, and then moves to powered down at the next edge.
- R4: While powered down, `xtal_en`, `fast_osc_en`, `pll_en` and `sysclk_en` are 0, and `slow_osc_en` equals bit 7.
- R5: The edge at which a wake pulse is taken in the powered-down state clears bit 0.
- R6: With bit 2 set and `clk_src_xtal` = 1 at wake, the state is 3 with `sysclk_en` = 0 for exactly LONG_DLY (4096) cycles, then returns to 0.
- R7: With bit 2 set and `clk_src_xtal` = 0 at wake, the delay lasts exactly SHORT_DLY (256) cycles.
- R8: With bit 2 clear, a wake goes straight back to the run state at the next edge.
- R9: A wake taken while powered down sets bit 4 only if bit 3 is 1. Writing 1 to bit 4 clears it.
- R10: `wake_irq` is 1 exactly when bit 4 and bit 3 are both 1.
- R11: Wake pulses outside the powered-down state, including while waiting for the CPU, change neither the state nor bit 4.
- R12: Outside power-down, `xtal_en`, `fast_osc_en` and `pll_en` follow bits 5, 6 and 8. `sysclk_en` is 1 only in states 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 9 | Control word write data |
| cfg_rdata | output | 9 | Control word read data |
| cpu_sleep | input | 1 | Processor has entered wait-for-interrupt sleep |
| wake_gpio | input | 1 | GPIO wake event |
| wake_uart | input | 1 | UART wake event |
| clk_src_xtal | input | 1 | 1 when the system clock runs from the crystal, 0 for the fast internal oscillator |
| xtal_en | output | 1 | Crystal oscillator enable |
| fast_osc_en | output | 1 | Fast internal oscillator enable |
| slow_osc_en | output | 1 | Slow internal oscillator enable |
| pll_en | output | 1 | PLL enable |
| sysclk_en | output | 1 | System clock gate enable |
| wake_irq | output | 1 | Wake interrupt |
| seq_state | output | 2 | Sequencer state code |

## Verification
A state register stuck in or skipping the waiting state shows up within one cycle on `seq_state` and `sysclk_en`, because the processor's sleep is then either ignored or not awaited. A wrong terminal count or a wrong source choice does not show until the wake window closes. It appears as a delay that is a few cycles or a whole source length off, counted on `sysclk_en`. A wrongly gated or set flag is visible on `cfg_rdata` bit 4 and on `wake_irq` at the first sample after the wake edge. A missing auto-clear is visible on bit 0 at that same sample.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

  localparam int REG_W = 9;

  localparam int F_ARM   = 0;
  localparam int F_WAIT  = 1;
  localparam int F_DLY   = 2;
  localparam int F_IRQEN = 3;
  localparam int F_FLAG  = 4;
  localparam int F_OSC0  = 5;   // bits 5..8: crystal, fast, slow, pll

  localparam int N_SRC = 4;
  localparam int S_XTAL = 0;
  localparam int S_FAST = 1;
  localparam int S_SLOW = 2;
  localparam int S_PLL  = 3;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_PD   = 2'd2,
    ST_DLY  = 2'd3
  } pdn_state_t;

  // terminal count loaded into the down-counter on the wake edge
  function automatic int unsigned dly_terminal(input logic xtal,
                                               input int unsigned long_c,
                                               input int unsigned short_c);
    return xtal ? (long_c - 1) : (short_c - 1);
  endfunction

endpackage

// File: rtl/pdn_ctrl_regs.sv
module pdn_ctrl_regs
  import pdn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             arm_clr,
  input  logic             wake_evt,
  output logic             arm,
  output logic             wait_cpu,
  output logic             dly_en,
  output logic             irq_en,
  output logic             flag,
  output logic [N_SRC-1:0] osc_on,
  output logic [REG_W-1:0] rd_data
);

  localparam logic [N_SRC-1:0] OSC_RST = 4'b0110;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm      <= 1'b0;
      wait_cpu <= 1'b0;
      dly_en   <= 1'b0;
      irq_en   <= 1'b0;
      osc_on   <= OSC_RST;
    end else begin
      if (arm_clr)    arm <= 1'b0;
      else if (wr_en) arm <= wr_data[F_ARM];
      if (wr_en) begin
        wait_cpu <= wr_data[F_WAIT];
        dly_en   <= wr_data[F_DLY];
        irq_en   <= wr_data[F_IRQEN];
        osc_on   <= wr_data[F_OSC0 +: N_SRC];
      end
    end
  end

  // sticky wake flag: set wins over a same-cycle write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag <= 1'b0;
    else if (wake_evt && irq_en)       flag <= 1'b1;
    else if (wr_en && wr_data[F_FLAG]) flag <= 1'b0;
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[F_ARM]           = arm;
    rd_data[F_WAIT]          = wait_cpu;
    rd_data[F_DLY]           = dly_en;
    rd_data[F_IRQEN]         = irq_en;
    rd_data[F_FLAG]          = flag;
    rd_data[F_OSC0 +: N_SRC] = osc_on;
  end

endmodule

// File: rtl/pdn_wake_timer.sv
module pdn_wake_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       wait_cpu,
  input  logic       dly_en,
  input  logic       cpu_sleep,
  input  logic       wake_any,
  input  logic       dly_done,
  output pdn_state_t state,
  output logic       wake_hit,
  output logic       load_dly
);

  pdn_state_t nxt;

  assign wake_hit = (state == ST_PD) && wake_any;
  assign load_dly = wake_hit && dly_en;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:  if (arm) nxt = wait_cpu ? ST_WAIT : ST_PD;
      ST_WAIT: begin
        if (!arm)                       nxt = ST_RUN;
        else if (cpu_sleep || !wait_cpu) nxt = ST_PD;
      end
      ST_PD:   if (wake_any) nxt = dly_en ? ST_DLY : ST_RUN;
      ST_DLY:  if (dly_done) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

endmodule

// File: rtl/pdn_clk_gate.sv
module pdn_clk_gate
  import pdn_pkg::*;
#(
  parameter logic [N_SRC-1:0] FORCE_OFF = 4'b1011
) (
  input  pdn_state_t       state,
  input  logic [N_SRC-1:0] osc_on,
  output logic [N_SRC-1:0] osc_en,
  output logic             sys_en
);

  logic in_pd;
  assign in_pd = (state == ST_PD);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (FORCE_OFF[g]) begin : g_forced
      assign osc_en[g] = osc_on[g] && !in_pd;
    end else begin : g_free
      assign osc_en[g] = osc_on[g];
    end
  end

  assign sys_en = (state == ST_RUN) || (state == ST_WAIT);

endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer
  import pdn_pkg::*;
#(
  parameter int unsigned LONG_DLY  = 4096,
  parameter int unsigned SHORT_DLY = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             cpu_sleep,
  input  logic             wake_gpio,
  input  logic             wake_uart,
  input  logic             clk_src_xtal,
  output logic             xtal_en,
  output logic             fast_osc_en,
  output logic             slow_osc_en,
  output logic             pll_en,
  output logic             sysclk_en,
  output logic             wake_irq,
  output logic [1:0]       seq_state
);

  localparam int CNT_W = $clog2(LONG_DLY);

  logic             arm, wait_cpu, dly_en, irq_en, flag;
  logic [N_SRC-1:0] osc_on, osc_en;
  logic             wake_any, wake_hit, load_dly, dly_done;
  logic [CNT_W-1:0] dly_val;
  pdn_state_t       state;

  assign wake_any = wake_gpio || wake_uart;
  assign dly_val  = CNT_W'(dly_terminal(clk_src_xtal, LONG_DLY, SHORT_DLY));

  pdn_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_data  (cfg_wdata),
    .arm_clr  (wake_hit),
    .wake_evt (wake_hit),
    .arm      (arm),
    .wait_cpu (wait_cpu),
    .dly_en   (dly_en),
    .irq_en   (irq_en),
    .flag     (flag),
    .osc_on   (osc_on),
    .rd_data  (cfg_rdata)
  );

  pdn_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .wait_cpu  (wait_cpu),
    .dly_en    (dly_en),
    .cpu_sleep (cpu_sleep),
    .wake_any  (wake_any),
    .dly_done  (dly_done),
    .state     (state),
    .wake_hit  (wake_hit),
    .load_dly  (load_dly)
  );

  pdn_wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_dly),
    .load_val (dly_val),
    .done     (dly_done)
  );

  pdn_clk_gate u_gate (
    .state  (state),
    .osc_on (osc_on),
    .osc_en (osc_en),
    .sys_en (sysclk_en)
  );

  assign xtal_en     = osc_en[S_XTAL];
  assign fast_osc_en = osc_en[S_FAST];
  assign slow_osc_en = osc_en[S_SLOW];
  assign pll_en      = osc_en[S_PLL];
  assign wake_irq    = flag && irq_en;
  assign seq_state   = state;

endmodule

// File: rtl/pdn_sequencer_chk.sv
module pdn_sequencer_chk
  import pdn_pkg::*;
#(
  parameter int unsigned LONG_DLY  = 4096,
  parameter int unsigned SHORT_DLY = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       seq_state,
  input logic             cpu_sleep,
  input logic             clk_src_xtal,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             wake_hit,
  input logic             sysclk_en,
  input logic             xtal_en,
  input logic             fast_osc_en,
  input logic             pll_en
);

  int unsigned chk_cnt, chk_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt <= 0;
      chk_exp <= 0;
    end else if (wake_hit) begin
      chk_cnt <= 0;
      chk_exp <= clk_src_xtal ? LONG_DLY : SHORT_DLY;
    end else if (seq_state == ST_DLY) begin
      chk_cnt <= chk_cnt + 1;
    end
  end

  p_imm_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_RUN && cfg_rdata[F_ARM] && !cfg_rdata[F_WAIT]) |=> seq_state == ST_PD);

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_WAIT && cfg_rdata[F_ARM] && cfg_rdata[F_WAIT] && !cpu_sleep)
      |=> seq_state == ST_WAIT);

  p_pd_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_PD) |-> (!xtal_en && !fast_osc_en && !pll_en && !sysclk_en));

  p_arm_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> !cfg_rdata[F_ARM]);

  // R6 and R7: settling window length measured by an independent counter
  p_dly_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_RUN && $past(seq_state) == ST_DLY) |-> chk_cnt == chk_exp);

  p_no_dly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && !cfg_rdata[F_DLY]) |=> seq_state == ST_RUN);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && cfg_rdata[F_IRQEN]) |=> cfg_rdata[F_FLAG]);

  p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != ST_PD && !cfg_rdata[F_FLAG]) |=> !cfg_rdata[F_FLAG]);

  p_sysclk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_PD || seq_state == ST_DLY) |-> !sysclk_en);

endmodule

bind pdn_sequencer pdn_sequencer_chk #(
  .LONG_DLY  (LONG_DLY),
  .SHORT_DLY (SHORT_DLY)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .seq_state    (seq_state),
  .cpu_sleep    (cpu_sleep),
  .clk_src_xtal (clk_src_xtal),
  .cfg_rdata    (cfg_rdata),
  .wake_hit     (wake_hit),
  .sysclk_en    (sysclk_en),
  .xtal_en      (xtal_en),
  .fast_osc_en  (fast_osc_en),
  .pll_en       (pll_en)
);

// File: tb/tb_pdn_sequencer.sv
module tb_pdn_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int LONG_D  = 4096;
  localparam int SHORT_D = 256;
  localparam int WDOG    = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [8:0] cfg_wdata = '0;
  logic [8:0] cfg_rdata;
  logic       cpu_sleep = 1'b0, wake_gpio = 1'b0, wake_uart = 1'b0, clk_src_xtal = 1'b0;
  logic       xtal_en, fast_osc_en, slow_osc_en, pll_en, sysclk_en, wake_irq;
  logic [1:0] seq_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdn_sequencer #(.LONG_DLY(LONG_D), .SHORT_DLY(SHORT_D)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cpu_sleep(cpu_sleep), .wake_gpio(wake_gpio),
    .wake_uart(wake_uart), .clk_src_xtal(clk_src_xtal), .xtal_en(xtal_en),
    .fast_osc_en(fast_osc_en), .slow_osc_en(slow_osc_en), .pll_en(pll_en),
    .sysclk_en(sysclk_en), .wake_irq(wake_irq), .seq_state(seq_state)
  );

  function automatic logic [8:0] word(bit arm, bit wt, bit dly, bit irq, bit clr,
                                      bit xo, bit fo, bit so, bit po);
    return {po, so, fo, xo, clr, irq, dly, wt, arm};
  endfunction

  function automatic int exp_window(bit dly, bit xtal);
    return dly ? (xtal ? LONG_D : SHORT_D) : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_wake(bit use_uart);
    if (use_uart) wake_uart = 1'b1; else wake_gpio = 1'b1;
    @(negedge clk);
    wake_uart = 1'b0; wake_gpio = 1'b0;
  endtask

  // one full sleep/wake round; returns at a negedge with the block back in run
  task automatic round(bit wt, bit dly, bit irq, bit xtal, bit xo, bit so, bit po,
                       int pre, bit use_uart);
    int n;
    wr(word(1, wt, dly, irq, 1, xo, 1, so, po));
    check("R12 sysclk on while armed", sysclk_en, 1);
    check("R12 xtal follows bit", xtal_en, xo);
    check("R12 pll follows bit", pll_en, po);
    @(negedge clk);
    if (wt) begin
      check("R3 waiting state", seq_state, 1);
      for (int i = 0; i < pre; i++) @(negedge clk);
      pulse_wake(use_uart);
      check("R11 wake ignored in wait (state)", seq_state, 1);
      check("R11 wake ignored in wait (flag)", cfg_rdata[4], 0);
      check("R3 sysclk on while waiting", sysclk_en, 1);
      cpu_sleep = 1'b1;
      @(negedge clk);
      cpu_sleep = 1'b0;
    end
    check("R2 R3 powered down", seq_state, 2);
    for (int i = 0; i < pre; i++) @(negedge clk);
    check("R4 xtal off", xtal_en, 0);
    check("R4 fast off", fast_osc_en, 0);
    check("R4 pll off", pll_en, 0);
    check("R4 sysclk off", sysclk_en, 0);
    check("R4 slow follows bit", slow_osc_en, so);
    clk_src_xtal = xtal;
    pulse_wake(use_uart);
    check("R5 arm cleared", cfg_rdata[0], 0);
    check("R9 flag after wake", cfg_rdata[4], irq);
    check("R10 irq after wake", wake_irq, irq);
    n = 0;
    while (seq_state == 2'd3 && n < 10000) begin
      if (sysclk_en) check("R6 R7 sysclk held off", sysclk_en, 0);
      n++;
      @(negedge clk);
    end
    check(dly ? (xtal ? "R6 crystal window" : "R7 fast window") : "R8 no window",
          n, exp_window(dly, xtal));
    check("R8 back in run", seq_state, 0);
    check("R12 sysclk back on", sysclk_en, 1);
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 state", seq_state, 0);
    check("R1 control word", cfg_rdata, 9'h0C0);
    check("R1 sysclk", sysclk_en, 1);
    check("R1 fast", fast_osc_en, 1);
    check("R1 slow", slow_osc_en, 1);
    check("R1 xtal", xtal_en, 0);
    check("R1 pll", pll_en, 0);
    check("R1 irq", wake_irq, 0);

    // wake in run is ignored
    pulse_wake(0);
    check("R11 wake ignored in run", seq_state, 0);

    // directed corners
    round(0, 1, 1, 1, 1, 1, 1, 2, 0);   // crystal window, R6
    check("R10 irq held", wake_irq, 1);
    wr(word(0, 0, 0, 1, 1, 0, 1, 1, 0));
    check("R9 flag cleared by write-one", cfg_rdata[4], 0);
    check("R10 irq drops", wake_irq, 0);
    round(1, 1, 0, 0, 0, 0, 0, 3, 1);   // fast window, no irq, R7
    check("R9 flag stays clear without irq enable", cfg_rdata[4], 0);
    round(0, 0, 1, 0, 1, 1, 1, 1, 1);   // no window, R8

    // random rounds
    for (int k = 0; k < 14; k++) begin
      bit wt, dly, irq, xt, xo, so, po, uu;
      int pre;
      wt  = $urandom_range(0, 1);
      dly = $urandom_range(0, 1);
      irq = $urandom_range(0, 1);
      xt  = ($urandom_range(0, 3) == 0);
      xo  = $urandom_range(0, 1);
      so  = $urandom_range(0, 1);
      po  = $urandom_range(0, 1);
      uu  = $urandom_range(0, 1);
      pre = $urandom_range(1, 6);
      round(wt, dly, irq, xt, xo, so, po, pre, uu);
      wr(word(0, 0, 0, irq, 1, xo, 1, so, po));
      check("R9 flag cleared", cfg_rdata[4], 0);
    end

    // disarm while waiting returns to run
    wr(word(1, 1, 0, 0, 1, 0, 1, 1, 0));
    @(negedge clk);
    check("R3 waiting before disarm", seq_state, 1);
    wr(word(0, 1, 0, 0, 0, 0, 1, 1, 0));
    @(negedge clk);
    check("R3 disarm leaves wait", seq_state, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule